// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM of 2^18 bytes. One request moves one byte. The controller drives the address lines, a low-true and a high-true chip select, a low-true output enable and a low-true write strobe. The bidirectional data bus appears as three signals: an output value, an output-enable for the pad tristate, and an input value. Between accesses both chip selects are released, so the memory stays in standby.

Each phase is counted in system-clock cycles. A phase takes the ceiling of the required time divided by the clock period, plus one cycle of margin. The required times are parameters: the read phase uses the longer of the address access time and the output-enable access time, the write phase uses the write-strobe width, and the recovery phase uses the bus release time. A read ends with a one-cycle `rd_valid` pulse that carries the byte. A write ends with a one-cycle `wr_done` pulse. A new request is taken only while `ready` is high.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, `ready`=1, `sram_ce_n`=1, `sram_ce`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `rd_valid`=0 and `wr_done`=0.
- R2: While `ready` is high, the memory is deselected (`sram_ce_n`=1, `sram_ce`=0) and `sram_dq_oe`=0.
- R3: A read accepted on clock edge E0 selects the memory with `sram_oe_n`=0, `sram_we_n`=1 and `sram_dq_oe`=0. It pulses `rd_valid` for one cycle after edge E0+RD_CYC. RD_CYC is ceil(max(read cycle, output-enable access)/clock period)+1, which is 4 at the default settings.
- R4: The data byte is sampled only after output enable and the selects have been held for RD_CYC cycles, which is at least the address access time.
- R5: A write accepted on edge E0 holds `sram_we_n` low for WR_CYC cycles (4 by default), with `sram_dq_oe`=1 and the byte on `sram_dq_out`. It pulses `wr_done` for one cycle after edge E0+WR_CYC+1.
- R6: For one cycle after `sram_we_n` rises, the address, the data and `sram_dq_oe` stay unchanged and the memory stays selected.
- R7: `sram_dq_oe` is never raised until `sram_oe_n` has been high for at least HZ_CYC cycles (2 by default), so the controller never drives while the memory may still be driving.
- R8: A request presented while `ready` is low is ignored. It causes no write to the memory.
- R9: A byte written to any address, including 0 and 0x3FFFF, reads back unchanged.
- R10: `sram_oe_n` and `sram_we_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, a request will be taken |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read byte |
| rd_data | output | 8 | Read byte |
| wr_done | output | 1 | One-cycle pulse: write finished |
| sram_addr | output | 18 | Memory address lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_ce | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_out | output | 8 | Data toward memory |
| sram_dq_oe | output | 1 | Pad drive enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Data from memory pads |

## Verification
A state register that is off by one phase, or a miscounted timer, shows up at once as a shifted `rd_valid` or `wr_done` pulse. The bench flags that latency on the same request. A read phase that is too short returns the memory model's filler byte instead of the stored byte, and the scoreboard catches it on that read. A lost hold cycle or a missed recovery wait shows up as a dropped write or as bus contention within a few cycles, and the model reports it. An accepted busy-time request shows up as a changed byte on the next read of that address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RREL  = 3'd2,
    ST_WR    = 3'd3,
    ST_WHOLD = 3'd4
  } ctl_state_t;

  function automatic int cyc_of(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns + 1;
  endfunction
endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= strobe;
      if (strobe) data <= din;
    end
  end

  // R3: the read strobe lasts one cycle
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_HZ_NS = 20,
  parameter int T_WP_NS = T_RC_NS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int T_RD_NS = (T_RC_NS > T_OE_NS) ? T_RC_NS : T_OE_NS;
  localparam int RD_CYC  = cyc_of(T_RD_NS, CLK_NS);
  localparam int WR_CYC  = cyc_of(T_WP_NS, CLK_NS);
  localparam int HZ_CYC  = cyc_of(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > HZ_CYC) ? RD_CYC : HZ_CYC)
                                             : ((WR_CYC > HZ_CYC) ? WR_CYC : HZ_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctl_state_t       st;
  logic             tmr_load, tmr_zero, rd_strobe, accept;
  logic [CNT_W-1:0] tmr_val;

  assign ready     = (st == ST_IDLE);
  assign accept    = ready && req_valid;
  assign rd_strobe = (st == ST_RD) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (rd_strobe) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(HZ_CYC - 1);
    end
  end

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst(rst), .strobe(rd_strobe), .din(sram_dq_in),
    .valid(rd_valid), .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      sram_addr   <= '0;
      sram_ce_n   <= 1'b1;
      sram_ce     <= 1'b0;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      wr_done     <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          sram_ce_n <= 1'b0;
          sram_ce   <= 1'b1;
          if (req_write) begin
            sram_we_n   <= 1'b0;
            sram_dq_out <= req_wdata;
            sram_dq_oe  <= 1'b1;
            st          <= ST_WR;
          end else begin
            sram_oe_n <= 1'b0;
            st        <= ST_RD;
          end
        end
        ST_RD: if (tmr_zero) begin
          sram_ce_n <= 1'b1;
          sram_ce   <= 1'b0;
          sram_oe_n <= 1'b1;
          st        <= ST_RREL;
        end
        ST_RREL: if (tmr_zero) st <= ST_IDLE;
        ST_WR: if (tmr_zero) begin
          sram_we_n <= 1'b1;
          st        <= ST_WHOLD;
        end
        ST_WHOLD: begin
          sram_ce_n  <= 1'b1;
          sram_ce    <= 1'b0;
          sram_dq_oe <= 1'b0;
          wr_done    <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker state: cycles since output enable was last released
  logic [CNT_W-1:0] oe_rel_cnt;
  always_ff @(posedge clk) begin
    if (rst)                          oe_rel_cnt <= CNT_W'(HZ_CYC);
    else if (!sram_oe_n)              oe_rel_cnt <= '0;
    else if (oe_rel_cnt < CNT_W'(HZ_CYC)) oe_rel_cnt <= oe_rel_cnt + 1'b1;
  end

  a_r2_idle_standby: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sram_ce_n && !sram_ce && !sram_dq_oe));

  a_r10_no_oe_we: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n));

  a_r6_write_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_addr) && $stable(sram_dq_out)));

  a_r7_bus_release: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (oe_rel_cnt >= CNT_W'(HZ_CYC)));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);
endmodule

// File: tb/tb_async_sram_ctl.sv
module tb_async_sram_ctl;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int RD_LAT = 4;
  localparam int WR_LAT = 5;
  localparam int T_AA_CYC = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rd_valid, wr_done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  always #10 clk = ~clk;

  async_sram_ctl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural memory model, updated away from the active edge
  logic [DW-1:0] mem [int];
  logic [DW-1:0] shadow [int];
  logic model_drv = 1'b0;
  logic [DW-1:0] model_dat = 8'hEE;
  int rd_run = 0, tail = 0;
  bit prev_rd = 0, prev_wr_lo = 0;
  assign sram_dq_in = model_drv ? model_dat : '0;

  function automatic logic [DW-1:0] memv(input int a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  always @(negedge clk) begin
    bit sel, rd_sel;
    sel    = !sram_ce_n && sram_ce;
    rd_sel = sel && sram_we_n && !sram_oe_n;
    if (!rst) begin
      if (!sram_oe_n && !sram_we_n) chk(0, "R10 oe/we both low", 0, 1);
      if (sel && !sram_we_n && !sram_dq_oe) chk(0, "R5 data not driven in write", 0, 1);
      if (sram_dq_oe && model_drv) chk(0, "R7 bus contention", 1, 0);
      if (ready && (!sram_ce_n || sram_ce || sram_dq_oe))
        chk(0, "R2 selected while idle", {sram_ce_n, sram_ce, sram_dq_oe}, 3'b100);
      if (prev_wr_lo && sram_we_n) begin
        if (sel && sram_dq_oe) mem[int'(sram_addr)] = sram_dq_out;
        else chk(0, "R6 no hold after write strobe", {sel, sram_dq_oe}, 2'b11);
      end
    end
    rd_run = rd_sel ? rd_run + 1 : 0;
    if (prev_rd && !rd_sel) tail = 1;
    else if (tail > 0) tail = tail - 1;
    prev_rd    = rd_sel;
    prev_wr_lo = sel && !sram_we_n;
    model_drv  = rd_sel || (tail > 0);
    if (rd_sel) model_dat = (rd_run >= T_AA_CYC) ? memv(int'(sram_addr)) : 8'hEE;
  end

  // Scoreboard
  typedef struct { logic [DW-1:0] data; int acc; int addr; } rexp_t;
  rexp_t rq[$];
  int    wq[$];

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (rq.size() == 0) chk(0, "R3 unexpected read strobe", 1, 0);
      else begin
        rexp_t e;
        e = rq.pop_front();
        chk(cyc == e.acc + RD_LAT, "R3 read latency", cyc - e.acc, RD_LAT);
        chk(rd_data == e.data, "R9/R4 read data", rd_data, e.data);
      end
    end
    if (!rst && wr_done) begin
      if (wq.size() == 0) chk(0, "R5 unexpected write done", 1, 0);
      else begin
        int a;
        a = wq.pop_front();
        chk(cyc == a + WR_LAT, "R5 write latency", cyc - a, WR_LAT);
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      shadow[int'(a)] = d;
      wq.push_back(cyc);
    end else begin
      rexp_t e;
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
      e.acc  = cyc;
      e.addr = int'(a);
      rq.push_back(e);
    end
  endtask

  task automatic drain;
    repeat (12) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk({sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe} == 5'b10110,
        "R1 pins", {sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    chk(!rd_valid && !wr_done, "R1 strobes", {rd_valid, wr_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R2 idle after reset", ready, 1);

    // R9: address extremes, then R3 pin state during a read
    issue(1, 18'h00000, 8'h5A);
    issue(1, 18'h3FFFF, 8'hC3);
    issue(0, 18'h00000, 8'h00);
    chk(!sram_oe_n && sram_we_n && !sram_dq_oe && !sram_ce_n && sram_ce,
        "R3 read pin state", {sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b01010);
    issue(0, 18'h3FFFF, 8'h00);
    drain();

    // R5: pin state during a write; R8: request during busy is ignored
    issue(1, 18'h01234, 8'h11);
    chk(!sram_we_n && sram_dq_oe && sram_dq_out == 8'h11 && sram_addr == 18'h01234,
        "R5 write pin state", {sram_we_n, sram_dq_oe, sram_dq_out}, {2'b01, 8'h11});
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h01234; req_wdata = 8'hFF;
    repeat (3) begin
      chk(!ready, "R8 busy", ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    issue(0, 18'h01234, 8'h00);
    drain();
    chk(memv(18'h01234) == 8'h11, "R8 busy request ignored", memv(18'h01234), 8'h11);

    // R7: read immediately followed by writes (bus turnaround)
    for (int i = 0; i < 6; i++) begin
      issue(0, 18'h00000, 8'h00);
      issue(1, 18'h00100 + 18'(i), 8'(i * 7 + 3));
    end
    for (int i = 0; i < 6; i++) issue(0, 18'h00100 + 18'(i), 8'h00);

    // R9: random addresses and data, interleaved
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom);
      d = DW'($urandom);
      issue(1, a, d);
      issue(0, a, 8'h00);
    end
    drain();
    chk(rq.size() == 0, "R3 all reads returned", rq.size(), 0);
    chk(wq.size() == 0, "R5 all writes completed", wq.size(), 0);
    chk(ready && sram_ce_n && !sram_ce, "R2 standby at end", {ready, sram_ce_n, sram_ce}, 3'b110);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule